// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This block sits beside a serial flash command sequencer and takes over the job of waiting for the memory to become ready. Once started, it asks the sequencer to issue a status-read command and collects the status bytes that come back. It then compares the status word against a programmable match value. Only the bit positions selected by a mask take part in the comparison. The match rule is selectable. In the all-bits rule, every selected bit must equal the match value. In the any-bit rule, one selected bit that equals the match value is enough.

Between polls the engine idles for a programmable number of clock cycles. A match sets a sticky flag, which drives an interrupt through an enable. With automatic stop enabled, the engine returns to idle on the first match. With automatic stop disabled, it keeps polling and sets the flag again on every later match, until it is aborted. The most recently assembled status word stays visible on `status_word` after polling ends.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, `busy`, `cmd_req`, `match_flag` and `irq` are low and `status_word` is zero.
- R2: A `start` pulse sampled while idle raises `busy` and `cmd_req` on the next cycle; `cmd_req` is high for exactly one cycle per poll.
- R3: After `cmd_req`, the engine accepts `cfg_size`+1 bytes on `rx_valid`/`rx_data` (cfg_size 0..3 means 1..4 bytes). The first byte lands in bits 7:0, the next in bits 15:8, and so on. The assembled word appears on `status_word` one cycle after the last byte, with unreceived bytes reading zero.
- R4: With `cfg_or_mode`=0, a poll matches when every bit selected by `cfg_mask` equals the same bit of `cfg_match`.
- R5: With `cfg_or_mode`=1, a poll matches when at least one bit selected by `cfg_mask` equals the same bit of `cfg_match`.
- R6: Bit positions above the configured status size never take part in the comparison, whatever `cfg_mask` holds there.
- R7: After a poll that does not stop the engine, the next `cmd_req` rises `cfg_interval`+1 cycles after the cycle in which the last status byte is sampled. With an interval of 0, it rises on the very next cycle.
- R8: With `cfg_auto_stop`=1, a match drops `busy` on the next cycle and no further `cmd_req` is issued.
- R9: With `cfg_auto_stop`=0, a match leaves `busy` high and polling continues. Each later match sets `match_flag` again.
- R10: `match_flag` is sticky and is cleared by `flag_clr`. A match in the same cycle as `flag_clr` wins, and the flag stays set.
- R11: `irq` is high exactly when `match_flag` and `cfg_irq_en` are both high.
- R12: `abort` returns the engine to idle on the next cycle and takes priority over `start`. While idle, received bytes are ignored and `status_word` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (ignored while busy) |
| abort | input | 1 | Stop polling immediately |
| flag_clr | input | 1 | Clear the sticky match flag |
| cfg_mask | input | 32 | Selects the compared bits |
| cfg_match | input | 32 | Value compared against the status word |
| cfg_or_mode | input | 1 | 0: all selected bits must equal; 1: any selected bit equal |
| cfg_auto_stop | input | 1 | Stop on the first match |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_interval | input | 16 | Idle cycles between polls |
| cfg_size | input | 2 | Status bytes per poll minus one |
| rx_valid | input | 1 | Status byte strobe from the sequencer |
| rx_data | input | 8 | Status byte |
| cmd_req | output | 1 | One-cycle request to issue the status-read command |
| busy | output | 1 | Polling in progress |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Interrupt |
| status_word | output | 32 | Last assembled status word |

## Verification
The embedded properties assume that the configuration inputs stay constant while `busy` is high. They also assume that the sequencer returns bytes only after a request, never more than `cfg_size`+1 per request. The bench changes configuration only while the engine is idle. Its sequencer model waits one cycle after each observed `cmd_req` before driving exactly the configured number of bytes. The one exception is a deliberate idle-time byte, used to show that such a byte is ignored.

// File: rtl/flash_status_poller.sv
module flash_status_poller #(
  parameter int MAX_BYTES = 4,
  parameter int GAP_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   abort,
  input  logic                   flag_clr,
  input  logic [8*MAX_BYTES-1:0] cfg_mask,
  input  logic [8*MAX_BYTES-1:0] cfg_match,
  input  logic                   cfg_or_mode,
  input  logic                   cfg_auto_stop,
  input  logic                   cfg_irq_en,
  input  logic [GAP_W-1:0]       cfg_interval,
  input  logic [((MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1)-1:0] cfg_size,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  output logic                   cmd_req,
  output logic                   busy,
  output logic                   match_flag,
  output logic                   irq,
  output logic [8*MAX_BYTES-1:0] status_word
);

  localparam int WORD_W = 8 * MAX_BYTES;
  localparam int SZ_W   = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RECV, S_GAP} state_t;

  state_t            state;
  logic [SZ_W-1:0]   byte_idx;
  logic [GAP_W-1:0]  gap_cnt;
  logic [WORD_W-1:0] partial;
  logic [WORD_W-1:0] word_next;
  logic [WORD_W-1:0] size_mask;
  logic [WORD_W-1:0] eff_mask;
  logic [WORD_W-1:0] diff;
  logic              last_byte;
  logic              hit;
  logic              hit_evt;

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
    assign size_mask[8*b +: 8] = (b <= int'(cfg_size)) ? 8'hFF : 8'h00;
  end

  assign word_next = partial | (WORD_W'(rx_data) << (8 * byte_idx));
  assign eff_mask  = cfg_mask & size_mask;
  assign diff      = word_next ^ cfg_match;
  assign hit       = cfg_or_mode ? |(~diff & eff_mask) : ~|(diff & eff_mask);
  assign last_byte = (state == S_RECV) && rx_valid && (byte_idx == cfg_size);
  assign hit_evt   = last_byte && hit && !abort;

  assign busy    = (state != S_IDLE);
  assign cmd_req = (state == S_ISSUE);
  assign irq     = match_flag & cfg_irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      byte_idx    <= '0;
      gap_cnt     <= '0;
      partial     <= '0;
      status_word <= '0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_ISSUE;
        S_ISSUE: begin
          partial  <= '0;
          byte_idx <= '0;
          state    <= S_RECV;
        end
        S_RECV: if (rx_valid) begin
          if (last_byte) begin
            status_word <= word_next;
            if (hit && cfg_auto_stop) begin
              state <= S_IDLE;
            end else if (cfg_interval == '0) begin
              state <= S_ISSUE;
            end else begin
              gap_cnt <= cfg_interval - 1'b1;
              state   <= S_GAP;
            end
          end else begin
            partial  <= word_next;
            byte_idx <= byte_idx + 1'b1;
          end
        end
        S_GAP: begin
          if (gap_cnt == '0) state <= S_ISSUE;
          else               gap_cnt <= gap_cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        match_flag <= 1'b0;
    else if (hit_evt)  match_flag <= 1'b1;
    else if (flag_clr) match_flag <= 1'b0;
  end

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !abort) |=> (busy && cmd_req));

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);

  // R8
  auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && cfg_auto_stop) |=> (!busy && !cmd_req));

  // R9
  keep_polling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !abort && !cfg_auto_stop) |=> busy);

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> match_flag);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit_evt) |=> !match_flag);

  // R12
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(status_word));

endmodule

// File: tb/tb_flash_status_poller.sv
module tb_flash_status_poller;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, abort, flag_clr;
  logic [31:0] cfg_mask, cfg_match;
  logic        cfg_or_mode, cfg_auto_stop, cfg_irq_en;
  logic [15:0] cfg_interval;
  logic [1:0]  cfg_size;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        cmd_req, busy, match_flag, irq;
  logic [31:0] status_word;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  flash_status_poller dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .flag_clr(flag_clr),
    .cfg_mask(cfg_mask), .cfg_match(cfg_match), .cfg_or_mode(cfg_or_mode),
    .cfg_auto_stop(cfg_auto_stop), .cfg_irq_en(cfg_irq_en),
    .cfg_interval(cfg_interval), .cfg_size(cfg_size),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .cmd_req(cmd_req), .busy(busy), .match_flag(match_flag), .irq(irq),
    .status_word(status_word)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual cycles %0d expected < 50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!cmd_req && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic send(input logic [31:0] w, input int nb);
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_valid = 1'b1; rx_data = w[8*i +: 8]; @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] sz, input logic [31:0] m, input logic [31:0] v,
                         input logic orm, input logic as, input logic [15:0] iv);
    cfg_size = sz; cfg_mask = m; cfg_match = v; cfg_or_mode = orm;
    cfg_auto_stop = as; cfg_interval = iv;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 0; abort = 0; flag_clr = 0; rx_valid = 0; rx_data = 0;
    cfg_irq_en = 1'b1;
    set_cfg(2'd0, 32'h0, 32'h0, 1'b0, 1'b1, 16'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    check(!busy && !cmd_req, "R1 busy/cmd_req", {30'b0, busy, cmd_req}, 32'h0);
    check(!match_flag && !irq, "R1 flag/irq", {30'b0, match_flag, irq}, 32'h0);
    check(status_word == 0, "R1 status_word", status_word, 32'h0);
  endtask

  task automatic t_and_autostop();
    int n;
    set_cfg(2'd0, 32'h1, 32'h0, 1'b0, 1'b1, 16'd0);
    do_start();
    check(busy && cmd_req, "R2 start raises busy and cmd_req", {30'b0, busy, cmd_req}, 32'h3);
    send(32'h03, 1);
    check(!match_flag, "R4 unmatched all-bits", {31'b0, match_flag}, 32'h0);
    check(cmd_req, "R7 zero interval re-issue next cycle", {31'b0, cmd_req}, 32'h1);
    send(32'h02, 1);
    check(match_flag, "R4 matched all-bits", {31'b0, match_flag}, 32'h1);
    check(!busy, "R8 auto stop drops busy", {31'b0, busy}, 32'h0);
    check(status_word == 32'h02, "R3 one-byte status", status_word, 32'h02);
    check(irq, "R11 irq with enable", {31'b0, irq}, 32'h1);
    n = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (cmd_req) n++; end
    check(n == 0, "R8 no request after stop", n, 0);
  endtask

  task automatic t_wide();
    int n;
    clear_flag();
    set_cfg(2'd3, 32'hFFFF_FFFF, 32'h1122_3344, 1'b0, 1'b1, 16'd0);
    do_start();
    send(32'h1122_3345, 4);
    check(status_word == 32'h1122_3345, "R3 four-byte LSB-first order", status_word, 32'h1122_3345);
    check(!match_flag && busy, "R4 one bit off no match", {30'b0, match_flag, busy}, 32'h1);
    wait_req(n);
    send(32'h1122_3344, 4);
    check(match_flag && !busy, "R4 four-byte match", {30'b0, match_flag, busy}, 32'h2);
  endtask

  task automatic t_size_mask();
    clear_flag();
    set_cfg(2'd1, 32'hFFFF_FFFF, 32'hFFFF_BEEF, 1'b0, 1'b1, 16'd0);
    do_start();
    send(32'h0000_BEEF, 2);
    check(status_word == 32'h0000_BEEF, "R3 two-byte upper zero", status_word, 32'h0000_BEEF);
    check(match_flag, "R6 bits above size ignored", {31'b0, match_flag}, 32'h1);
  endtask

  task automatic t_or();
    int n;
    clear_flag();
    set_cfg(2'd0, 32'h0F, 32'h05, 1'b1, 1'b1, 16'd0);
    do_start();
    send(32'h0A, 1);
    check(!match_flag, "R5 any-bit no equal bit", {31'b0, match_flag}, 32'h0);
    wait_req(n);
    send(32'h0B, 1);
    check(match_flag, "R5 any-bit single equal bit", {31'b0, match_flag}, 32'h1);
  endtask

  task automatic t_interval();
    int n;
    clear_flag();
    set_cfg(2'd0, 32'h1, 32'h0, 1'b0, 1'b1, 16'd3);
    do_start();
    send(32'h01, 1);
    wait_req(n);
    check(n == 3, "R7 interval 3 gap", n, 3);
    send(32'h00, 1);
    check(!busy, "R8 stop after gap poll", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_continuous();
    int n;
    clear_flag();
    set_cfg(2'd0, 32'h1, 32'h0, 1'b0, 1'b0, 16'd2);
    do_start();
    send(32'h00, 1);
    check(match_flag && busy, "R9 match keeps busy", {30'b0, match_flag, busy}, 32'h3);
    wait_req(n);
    check(n == 2, "R9 polling continues after gap", n, 2);
    clear_flag();
    check(!match_flag, "R10 flag cleared", {31'b0, match_flag}, 32'h0);
    wait_req(n);
    send(32'h01, 1);
    check(!match_flag, "R10 stays clear on miss", {31'b0, match_flag}, 32'h0);
    wait_req(n);
    send(32'h00, 1);
    check(match_flag, "R9 re-flag on later match", {31'b0, match_flag}, 32'h1);
    clear_flag();
    wait_req(n);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h10; flag_clr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; flag_clr = 1'b0;
    check(match_flag, "R10 set wins over clear", {31'b0, match_flag}, 32'h1);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    check(!busy, "R12 abort idles", {31'b0, busy}, 32'h0);
    repeat (4) @(negedge clk);
    check(!busy && !cmd_req, "R12 stays idle after abort", {30'b0, busy, cmd_req}, 32'h0);
    check(status_word == 32'h10, "R12 last word retained", status_word, 32'h10);
  endtask

  task automatic t_irq_and_idle();
    cfg_irq_en = 1'b0; @(negedge clk);
    check(match_flag && !irq, "R11 irq masked", {30'b0, match_flag, irq}, 32'h2);
    cfg_irq_en = 1'b1; @(negedge clk);
    check(irq, "R11 irq enabled", {31'b0, irq}, 32'h1);
    rx_valid = 1'b1; rx_data = 8'hAA; @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    check(status_word == 32'h10, "R12 idle byte ignored", status_word, 32'h10);
    start = 1'b1; abort = 1'b1; @(negedge clk); start = 1'b0; abort = 1'b0;
    check(!busy && !cmd_req, "R12 abort beats start", {30'b0, busy, cmd_req}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_and_autostop();
    t_wide();
    t_size_mask();
    t_or();
    t_interval();
    t_continuous();
    t_irq_and_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule